// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

This block holds two independent 8-bit down-counting timers. Each one is driven by its own 6-bit prescaler. The internal count source is the system clock divided by four. Both timers are programmed through a small register interface with select, write and read. Software writes a prescaler modulo and an initial count, then starts the timer. Each timer produces a one-cycle interrupt pulse when its count expires. After that it either halts or reloads and keeps running.

Timer zero always counts the internal source. Timer one can instead count falling edges of an asynchronous external pin. While timer one runs on the internal source, the same pin can gate it or trigger it. A trigger either restarts a running count or is ignored while a count is in progress. The pin passes through a two-flop synchroniser before any of these uses.

Top module: `dual_prescaled_timer`

## Requirements
- R1: After a cycle with rst_n low, the control register (select 0) reads 0x00, both counter registers read 0x00 and neither interrupt output is high.
- R2: With the internal source, prescaler modulo P and initial count C, the interrupt pulses of a modulo-mode timer are exactly 4*P*C clock cycles apart. Each pulse lasts one cycle.
- R3: A prescaler modulo written as 0 divides by 64. An initial count written as 0 counts 256 steps.
- R4: In single-pass mode (prescaler register bit 0 = 0) a timer gives exactly one interrupt pulse per start. Afterwards its counter reads 0 and it stays stopped.
- R5: In modulo mode (prescaler register bit 0 = 1) a timer reloads its initial count at expiry and keeps producing pulses.
- R6: The control register has these fields: bit 0 starts timer zero, bit 1 enables timer zero, bit 2 starts timer one, bit 3 enables timer one, and bits 5:4 select the pin mode (00 clock, 01 gate, 10 one-shot trigger, 11 restart trigger). Start bits and bits 7:6 read back 0. The prescaler registers (select 2 for timer one, select 4 for timer zero) are write-only and read 0. In a prescaler register, bits 7:2 hold the modulo.
- R7: Reading a counter register (select 1 for timer one, select 3 for timer zero) returns the live count without disturbing it. Writing it only changes the initial value used by the next start or reload.
- R8: Clearing a timer's enable bit freezes its count. Setting the bit again resumes counting from the frozen value without reloading.
- R9: With timer-one prescaler bit 1 = 0, timer one advances once per falling edge of ext_in and ignores the internal source.
- R10: In gate mode (01) with the internal source, timer one advances only while ext_in is high.
- R11: In one-shot trigger mode (10), a falling edge of ext_in starts timer one from its initial values. Edges that arrive while that count is running are ignored.
- R12: In restart trigger mode (11), every falling edge of ext_in restarts timer one from its initial values, including edges during a running count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| ext_in | input | 1 | Asynchronous external timer pin |
| irq_t0 | output | 1 | One-cycle expiry pulse of timer zero |
| irq_t1 | output | 1 | One-cycle expiry pulse of timer one |

## Verification
A prescaler or counter that slips by one step shows up at the first expiry as a pulse spacing off by a multiple of four cycles. In a readback it shows up as a count difference across an exact 4N-cycle window that is off by at least one. A timer that fails to stop, reload or freeze shows up within one internal tick (four cycles) in a counter read, or as an extra or missing pulse. A pin mode that is decoded wrongly shows up as a trigger that fires at the wrong time, either tens of cycles early or late. It can also show up as a gated count that differs from exactly one step per four high cycles.

// File: rtl/dptmr_pkg.sv
// Shared constants and types of the dual prescaled timer.
// Assumes a 3-bit register select; the field layout is fixed by software.
package dptmr_pkg;
    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_CTL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CNT1 = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PRE1 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CNT0 = 3'd3;
    localparam logic [SEL_W-1:0] SEL_PRE0 = 3'd4;

    typedef enum logic [1:0] {
        PIN_CLOCK     = 2'b00,
        PIN_GATE      = 2'b01,
        PIN_TRIG_ONCE = 2'b10,
        PIN_TRIG_RE   = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/dptmr_clk_src.sv
// Count-source generator: a free-running divider gives one internal tick
// every 2**DIV_W clocks, and a synchroniser turns the asynchronous pin into
// a level and a one-cycle falling-edge strobe.
// Assumes the pin is held for at least two clocks per level.
module dptmr_clk_src #(
    parameter int DIV_W  = 2,
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic tick,
    output logic pin_level,
    output logic pin_fall
);
    localparam int CHAIN_W = SYNC_N + 1;

    logic [DIV_W-1:0]   div_q;
    logic [CHAIN_W-1:0] chain_q;

    // Free-running divider for the internal tick.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Synchroniser chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], pin_async};
    end

    assign tick      = &div_q;
    assign pin_level = chain_q[SYNC_N-1];
    assign pin_fall  = chain_q[SYNC_N] & ~chain_q[SYNC_N-1];
endmodule

// File: rtl/dptmr_unit.sv
// One timer channel: a prescaler that divides the step strobe by 1..2**PRE_W
// (0 encodes the maximum) feeding a down counter of 1..2**CNT_W steps
// (0 encodes the maximum). A registered one-cycle pulse marks expiry.
// Assumes step is never high on two consecutive cycles.
module dptmr_unit #(
    parameter int PRE_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run_en,
    input  logic             step,
    input  logic             modulo,
    input  logic [PRE_W-1:0] pre_init,
    input  logic [CNT_W-1:0] cnt_init,
    output logic [CNT_W-1:0] cnt_now,
    output logic             busy,
    output logic             expire
);
    logic [PRE_W-1:0] pre_now;
    logic             adv;
    logic             pre_last;
    logic             cnt_last;

    assign adv      = step && run_en && busy;
    assign pre_last = (pre_now == PRE_W'(1));
    assign cnt_last = (cnt_now == CNT_W'(1));

    // Prescaler, counter, run flag and expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_now <= '0;
            cnt_now <= '0;
            busy    <= 1'b0;
            expire  <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (start) begin
                pre_now <= pre_init;
                cnt_now <= cnt_init;
                busy    <= 1'b1;
            end else if (adv) begin
                if (pre_last) begin
                    pre_now <= pre_init;
                    if (cnt_last) begin
                        expire <= 1'b1;
                        if (modulo) begin
                            cnt_now <= cnt_init;
                        end else begin
                            cnt_now <= '0;
                            busy    <= 1'b0;
                        end
                    end else begin
                        cnt_now <= cnt_now - 1'b1;
                    end
                end else begin
                    pre_now <= pre_now - 1'b1;
                end
            end
        end
    end

    // R4: a single-pass expiry leaves the channel stopped at zero.
    p_single_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !$past(modulo) |-> !busy && cnt_now == '0);

    // R5: a modulo expiry reloads the initial count.
    p_modulo_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire && $past(modulo) |-> busy && cnt_now == $past(cnt_init));

    // R8: with enable low and no start, the count holds.
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en && !start |=> $stable(cnt_now));

    // R2: an expiry never follows an expiry on the next cycle.
    p_expire_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
endmodule

// File: rtl/dual_prescaled_timer.sv
// Two prescaled down-counter timers behind a select/write/read register
// interface. Timer zero counts the internal tick only. Timer one counts the
// internal tick (optionally gated or triggered by the pin) or pin edges.
// Assumes single-cycle write strobes and a pin slower than half the clock.
module dual_prescaled_timer
    import dptmr_pkg::*;
#(
    parameter int PRE_W = 6,
    parameter int CNT_W = 8,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             ext_in,
    output logic             irq_t0,
    output logic             irq_t1
);
    localparam int PRE_LSB = 2;
    localparam int PRE_MSB = PRE_LSB + PRE_W - 1;

    logic             en0_q, en1_q;
    pin_mode_e        pmode_q;
    logic             mod0_q, mod1_q, int1_q;
    logic [PRE_W-1:0] pre0_q, pre1_q;
    logic [CNT_W-1:0] ini0_q, ini1_q;
    logic [CNT_W-1:0] cnt0, cnt1;
    logic             busy0, busy1;
    logic             tick, pin_level, pin_fall;
    logic             wr_ctl;
    logic             start0, start1;
    logic             step1, trig1;

    assign wr_ctl = reg_wr && (reg_sel == SEL_CTL);
    assign start0 = wr_ctl && reg_wdata[0];

    // Control, prescaler and initial-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en0_q   <= 1'b0;
            en1_q   <= 1'b0;
            pmode_q <= PIN_CLOCK;
            mod0_q  <= 1'b0;
            mod1_q  <= 1'b0;
            int1_q  <= 1'b0;
            pre0_q  <= '0;
            pre1_q  <= '0;
            ini0_q  <= '0;
            ini1_q  <= '0;
        end else if (reg_wr) begin
            unique case (reg_sel)
                SEL_CTL: begin
                    en0_q   <= reg_wdata[1];
                    en1_q   <= reg_wdata[3];
                    pmode_q <= pin_mode_e'(reg_wdata[5:4]);
                end
                SEL_PRE0: begin
                    mod0_q <= reg_wdata[0];
                    pre0_q <= reg_wdata[PRE_MSB:PRE_LSB];
                end
                SEL_PRE1: begin
                    mod1_q <= reg_wdata[0];
                    int1_q <= reg_wdata[1];
                    pre1_q <= reg_wdata[PRE_MSB:PRE_LSB];
                end
                SEL_CNT0: ini0_q <= reg_wdata[CNT_W-1:0];
                SEL_CNT1: ini1_q <= reg_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Timer-one step source and pin-trigger decode.
    always_comb begin
        step1 = tick;
        trig1 = 1'b0;
        if (!int1_q) begin
            step1 = pin_fall;
        end else begin
            unique case (pmode_q)
                PIN_CLOCK:     step1 = tick;
                PIN_GATE:      step1 = tick && pin_level;
                PIN_TRIG_ONCE: trig1 = pin_fall && !busy1;
                PIN_TRIG_RE:   trig1 = pin_fall;
            endcase
        end
    end

    assign start1 = (wr_ctl && reg_wdata[2]) || trig1;

    // Read-back multiplexer; start bits and write-only registers read 0.
    always_comb begin
        reg_rdata = 8'h00;
        unique case (reg_sel)
            SEL_CTL:  reg_rdata = {2'b00, pmode_q, en1_q, 1'b0, en0_q, 1'b0};
            SEL_CNT0: reg_rdata = 8'(cnt0);
            SEL_CNT1: reg_rdata = 8'(cnt1);
            default:  reg_rdata = 8'h00;
        endcase
    end

    dptmr_clk_src #(.DIV_W(DIV_W), .SYNC_N(2)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (ext_in),
        .tick      (tick),
        .pin_level (pin_level),
        .pin_fall  (pin_fall)
    );

    dptmr_unit #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_t0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start0),
        .run_en   (en0_q),
        .step     (tick),
        .modulo   (mod0_q),
        .pre_init (pre0_q),
        .cnt_init (ini0_q),
        .cnt_now  (cnt0),
        .busy     (busy0),
        .expire   (irq_t0)
    );

    dptmr_unit #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_t1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start1),
        .run_en   (en1_q),
        .step     (step1),
        .modulo   (mod1_q),
        .pre_init (pre1_q),
        .cnt_init (ini1_q),
        .cnt_now  (cnt1),
        .busy     (busy1),
        .expire   (irq_t1)
    );

    // R1: reset clears control state and interrupt outputs.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !irq_t0 && !irq_t1 && !en0_q && !en1_q && !busy0 && !busy1);

    // R8: an expiry pulse implies the timer was enabled.
    p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_t0 |-> $past(en0_q));

    // R11: a one-shot trigger never starts timer one while it is busy.
    p_trig_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        int1_q && pmode_q == PIN_TRIG_ONCE && busy1 && !wr_ctl |=> $past(cnt1) == cnt1 || !en1_q || step1 || $past(step1));

    // R2: timer-one expiry is a one-cycle pulse.
    p_irq1_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_t1 |=> !irq_t1);
endmodule

// File: tb/dual_prescaled_timer_tb.sv
`timescale 1ns/1ps
module dual_prescaled_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ext_in = 1'b0;
    logic       irq_t0, irq_t1;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int cyc = 0;
    int n0 = 0, n1 = 0;
    int last0 = 0, last1 = 0, gap0 = 0, gap1 = 0;

    always #2.5 clk = ~clk;

    dual_prescaled_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ext_in    (ext_in),
        .irq_t0    (irq_t0),
        .irq_t1    (irq_t1)
    );

    // Pulse monitor sampled away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (irq_t0) begin n0 <= n0 + 1; gap0 <= cyc - last0; last0 <= cyc; end
        if (irq_t1) begin n1 <= n1 + 1; gap1 <= cyc - last1; last1 <= cyc; end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output int d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_pulse(input int hi, input int lo);
        ext_in = 1'b1; idle(hi);
        ext_in = 1'b0; idle(lo);
    endtask

    task automatic clear_counts();
        @(negedge clk);
        n0 = 0; n1 = 0;
    endtask

    task automatic t_reset();
        int v;
        rd(3'd0, v); check("R1 ctl", v, 0);
        rd(3'd3, v); check("R1 cnt0", v, 0);
        rd(3'd1, v); check("R1 cnt1", v, 0);
        check("R1 irq", int'(irq_t0 | irq_t1), 0);
    endtask

    task automatic t_regmap();
        int v;
        wr(3'd0, 8'hFF);
        rd(3'd0, v); check("R6 ctl readback", v, 8'h3A);
        wr(3'd0, 8'h00);
        rd(3'd0, v); check("R6 ctl cleared", v, 0);
        wr(3'd4, 8'hFD);
        rd(3'd4, v); check("R6 pre0 write-only", v, 0);
        wr(3'd2, 8'hFF);
        rd(3'd2, v); check("R6 pre1 write-only", v, 0);
    endtask

    task automatic t_period();
        wr(3'd4, 8'h05); wr(3'd3, 8'd3);
        clear_counts();
        wr(3'd0, 8'h03);
        idle(200);
        check("R2 gap P1 C3", gap0, 12);
        check_rng("R5 modulo repeats", n0, 16, 17);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_big();
        wr(3'd4, 8'h01); wr(3'd3, 8'd2);
        wr(3'd2, 8'h07); wr(3'd1, 8'd0);
        clear_counts();
        wr(3'd0, 8'h0F);
        idle(2600);
        check("R3 prescale 0 is 64", gap0, 512);
        check("R3 count 0 is 256", gap1, 1024);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_single();
        int v;
        wr(3'd4, 8'h04); wr(3'd3, 8'd5);
        clear_counts();
        wr(3'd0, 8'h03);
        idle(100);
        check("R4 one pulse", n0, 1);
        rd(3'd3, v); check("R4 stopped at 0", v, 0);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_readback_pause();
        int a, b, c, d, e;
        wr(3'd4, 8'h05); wr(3'd3, 8'd200);
        wr(3'd0, 8'h03);
        idle(20);
        rd(3'd3, a);
        idle(199);
        rd(3'd3, b);
        check("R7 live decrement", a - b, 50);
        idle(97); wr(3'd3, 8'd50); idle(100);
        rd(3'd3, c);
        check("R7 write keeps count", b - c, 50);
        wr(3'd0, 8'h00);
        rd(3'd3, d); idle(100); rd(3'd3, e);
        check("R8 frozen", e, d);
        wr(3'd0, 8'h02);
        idle(199);
        rd(3'd3, a);
        check_rng("R8 resumes", e - a, 49, 51);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_extclk();
        int v;
        wr(3'd2, 8'h04); wr(3'd1, 8'd3);
        clear_counts();
        wr(3'd0, 8'h0C);
        idle(40);
        pin_pulse(4, 4); pin_pulse(4, 6);
        rd(3'd1, v); check("R9 two edges", v, 1);
        check("R9 no pulse yet", n1, 0);
        pin_pulse(4, 6);
        check("R9 expiry on third edge", n1, 1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_gate();
        int a, b, c;
        wr(3'd2, 8'h07); wr(3'd1, 8'd200);
        wr(3'd0, 8'h1C);
        rd(3'd1, a); idle(99); rd(3'd1, b);
        check("R10 gate closed", b, 200);
        ext_in = 1'b1; idle(400); ext_in = 1'b0;
        idle(10);
        rd(3'd1, c);
        check("R10 gated steps", c, 100);
        wr(3'd0, 8'h00);
    endtask

    task automatic finish_t1();
        wr(3'd2, 8'h06); wr(3'd1, 8'd1);
        wr(3'd0, 8'h0C);
        idle(20);
        wr(3'd1, 8'd10);
    endtask

    task automatic t_trig_once();
        finish_t1();
        clear_counts();
        wr(3'd0, 8'h28);
        idle(10);
        pin_pulse(4, 16);
        pin_pulse(4, 30);
        check("R11 second edge ignored", n1, 1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_trig_re();
        finish_t1();
        clear_counts();
        wr(3'd0, 8'h38);
        idle(10);
        pin_pulse(4, 16);
        pin_pulse(4, 30);
        check("R12 restarted, not done", n1, 0);
        idle(30);
        check("R12 done after restart", n1, 1);
        wr(3'd0, 8'h00);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_period();
        t_big();
        t_single();
        t_readback_pause();
        t_extclk();
        t_gate();
        t_trig_once();
        t_trig_re();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule